// File: doc/BRIEF.md
# DMA Graceful Stop and Transmit Poll Sequencer

This block watches writes to a DMA control word and turns three of its bits into timed actions. Two bits ask the receive and transmit DMA paths to halt gracefully. A request completes in the cycle after the write when the matching path is idle. When that path is in the middle of a frame, the request waits, and it completes on that path's end-of-frame pulse. Each completion is a single-cycle event pulse for the interrupt logic.

The third bit selects wait mode. Any control write with this bit clear starts a poll timer from zero. The timer counts ticks from an external prescaler, and after `TICKS` ticks it asks the transmit side to rescan descriptor ring 0. It then reloads and keeps running. The request is skipped while a graceful transmit stop is held, but the timer keeps its period. A write with the wait bit set stops the timer. The default of 100 ticks gives a 100 Hz poll rate from a 10 kHz tick.

Top module: `dma_stop_poll_ctrl`

## Requirements
- R1: A control write with bit 4 (receive stop) set while `rx_busy` is low gives `rx_stop_done` high in the following cycle.
- R2: A control write with bit 4 set while `rx_busy` is high gives no pulse. The request stays pending, and `rx_stop_done` goes high in the cycle after the next `rx_eof`.
- R3: Bit 3 (transmit stop) behaves the same way, using `tx_busy` and `tx_eof` and pulsing `tx_stop_done`.
- R4: A control write with a stop bit clear cancels any pending completion for that path, so a later end-of-frame pulse produces no event.
- R5: A control write with bit 6 (wait mode) clear restarts the timer. `poll_req` goes high in the cycle after the `TICKS`-th `tick` that follows the write, and never earlier.
- R6: While the timer runs, `poll_req` repeats once every `TICKS` ticks and is high for one cycle each time.
- R7: A poll that falls due while the last written bit 3 is set issues no `poll_req`, and the timer keeps its period.
- R8: A control write with bit 6 set stops the timer, and no `poll_req` is issued until a later write clears bit 6.
- R9: After reset every output is low and the timer is stopped.
- R10: Every completion and poll output is a one-cycle pulse for each triggering event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | CTL_W | Control word data |
| rx_busy | input | 1 | Receive frame in progress |
| tx_busy | input | 1 | Transmit frame in progress |
| rx_eof | input | 1 | Receive end-of-frame pulse |
| tx_eof | input | 1 | Transmit end-of-frame pulse |
| tick | input | 1 | Prescaler tick |
| rx_stop_done | output | 1 | Receive graceful stop complete pulse |
| tx_stop_done | output | 1 | Transmit graceful stop complete pulse |
| poll_req | output | 1 | Request to rescan transmit ring 0 |

## Verification
The bench targets the following failures:
- A stop requested mid-frame. A design that ignores the busy flag signals completion too early.
- A stop bit cleared before the frame ends. A design that keeps the pending flag raises a stale event.
- The poll boundary. An off-by-one counter polls at tick `TICKS-1` or `TICKS+1`, and a design that fails to restart on a write keeps the old phase.
- A write and an end-of-frame pulse in the same cycle. A design with the wrong precedence loses or duplicates an event.
- Polls that fall due while the transmit stop is held. A design that fails to gate them still issues requests.

// File: rtl/dma_stop_poll_ctrl.sv
module dma_stop_poll_ctrl #(
  parameter int CTL_W   = 32,
  parameter int GRS_BIT = 4,
  parameter int GTS_BIT = 3,
  parameter int WOP_BIT = 6,
  parameter int TICKS   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             rx_busy,
  input  logic             tx_busy,
  input  logic             rx_eof,
  input  logic             tx_eof,
  input  logic             tick,
  output logic             rx_stop_done,
  output logic             tx_stop_done,
  output logic             poll_req
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          rx_pend, tx_pend, gts_q, armed;
  logic [CW-1:0] cnt;

  wire req_rx = ctl_wdata[GRS_BIT];
  wire req_tx = ctl_wdata[GTS_BIT];
  wire wop    = ctl_wdata[WOP_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_stop_done <= 1'b0;
      tx_stop_done <= 1'b0;
      rx_pend      <= 1'b0;
      tx_pend      <= 1'b0;
      gts_q        <= 1'b0;
      armed        <= 1'b0;
      cnt          <= '0;
      poll_req     <= 1'b0;
    end else begin
      rx_stop_done <= ctl_we ? (req_rx & ~rx_busy) : (rx_pend & rx_eof);
      rx_pend      <= ctl_we ? (req_rx & rx_busy)  : (rx_pend & ~rx_eof);
      tx_stop_done <= ctl_we ? (req_tx & ~tx_busy) : (tx_pend & tx_eof);
      tx_pend      <= ctl_we ? (req_tx & tx_busy)  : (tx_pend & ~tx_eof);
      poll_req     <= 1'b0;
      if (ctl_we) begin
        gts_q <= req_tx;
        armed <= ~wop;
        cnt   <= '0;
      end else if (armed && tick) begin
        if (cnt == LAST) begin
          cnt      <= '0;
          poll_req <= ~gts_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_rx_now_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && req_rx && !rx_busy |=> rx_stop_done);
  assert_rx_defer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && req_rx && rx_busy |=> !rx_stop_done);
  assert_tx_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && req_tx && !tx_busy |=> tx_stop_done);
  assert_tx_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && req_tx && tx_busy |=> !tx_stop_done);
  assert_rx_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !req_rx ##1 !ctl_we && rx_eof |=> !rx_stop_done);
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !wop |=> !poll_req);
  assert_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |-> !$past(gts_q));
  assert_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && wop |=> !poll_req);
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> !poll_req);
endmodule

// File: tb/dma_stop_poll_ctrl_test.sv
module dma_stop_poll_ctrl_test;
  localparam int N = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, rx_busy = 0, tx_busy = 0, rx_eof = 0, tx_eof = 0, tick = 0;
  logic [31:0] ctl_wdata = '0;
  logic rx_stop_done, tx_stop_done, poll_req;
  int total = 0, bad = 0;
  bit done = 0;

  bit m_rp, m_tp, m_gts, m_arm;
  int m_cnt;

  always #10 clk = ~clk;

  dma_stop_poll_ctrl #(.TICKS(N)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rx_busy(rx_busy), .tx_busy(tx_busy), .rx_eof(rx_eof), .tx_eof(tx_eof),
    .tick(tick), .rx_stop_done(rx_stop_done), .tx_stop_done(tx_stop_done),
    .poll_req(poll_req));

  function automatic bit exp_rx();
    return ctl_we ? (ctl_wdata[4] && !rx_busy) : (m_rp && rx_eof);
  endfunction
  function automatic bit exp_tx();
    return ctl_we ? (ctl_wdata[3] && !tx_busy) : (m_tp && tx_eof);
  endfunction
  function automatic bit exp_poll();
    return !ctl_we && m_arm && tick && (m_cnt == N - 1) && !m_gts;
  endfunction

  task automatic check(input logic act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit we, input logic [31:0] d, input bit rb, input bit tb,
                     input bit re, input bit te, input bit tk, input string tag);
    bit er, et, ep;
    ctl_we = we; ctl_wdata = d; rx_busy = rb; tx_busy = tb;
    rx_eof = re; tx_eof = te; tick = tk;
    er = exp_rx(); et = exp_tx(); ep = exp_poll();
    @(negedge clk);
    check(rx_stop_done, er, {tag, " rx"});
    check(tx_stop_done, et, {tag, " tx"});
    check(poll_req, ep, {tag, " poll"});
    if (we) begin
      m_rp = d[4] && rb; m_tp = d[3] && tb; m_gts = d[3]; m_arm = !d[6]; m_cnt = 0;
    end else begin
      m_rp = m_rp && !re; m_tp = m_tp && !te;
      if (m_arm && tk) m_cnt = (m_cnt == N - 1) ? 0 : m_cnt + 1;
    end
  endtask

  task automatic idle(input int n, input bit tk, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tk, tag);
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(rx_stop_done, 0, "R9 reset rx");
    check(tx_stop_done, 0, "R9 reset tx");
    check(poll_req, 0, "R9 reset poll");
    rst_n = 1;
    idle(12, 1, "R9 idle timer");
    cyc(1, 32'h10, 0, 0, 0, 0, 0, "R1 immediate");
    idle(1, 0, "R10 rx pulse");
    cyc(1, 32'h10, 1, 0, 0, 0, 0, "R2 deferred");
    idle(3, 0, "R2 wait");
    cyc(0, 0, 1, 0, 1, 0, 0, "R2 eof");
    cyc(0, 0, 0, 0, 1, 0, 0, "R10 second eof");
    cyc(1, 32'h10, 1, 0, 0, 0, 0, "R4 arm");
    cyc(1, 32'h00, 1, 0, 0, 0, 0, "R4 clear");
    cyc(0, 0, 0, 0, 1, 0, 0, "R4 eof ignored");
    cyc(1, 32'h48, 0, 0, 0, 0, 0, "R3 immediate");
    cyc(1, 32'h48, 0, 1, 0, 0, 0, "R3 deferred");
    cyc(0, 0, 0, 1, 0, 1, 0, "R3 eof");
    cyc(1, 32'h48, 0, 1, 0, 0, 0, "R4 tx arm");
    cyc(1, 32'h40, 0, 1, 0, 0, 0, "R4 tx clear");
    cyc(0, 0, 0, 0, 0, 1, 0, "R4 tx eof ignored");
    cyc(1, 32'h0, 0, 0, 0, 0, 0, "R5 start");
    idle(N * 3, 1, "R6 periodic");
    cyc(0, 0, 0, 0, 0, 0, 1, "R5 restart pre");
    cyc(1, 32'h0, 0, 0, 0, 0, 1, "R5 restart");
    for (int i = 0; i < N + 2; i++) cyc(0, 0, 0, 0, 0, 0, i % 2, "R5 sparse ticks");
    cyc(1, 32'h08, 0, 0, 0, 0, 0, "R7 hold tx");
    idle(N * 2 + 1, 1, "R7 gated");
    cyc(1, 32'h0, 0, 0, 0, 0, 0, "R7 release");
    idle(N + 1, 1, "R7 resumes");
    cyc(1, 32'h40, 0, 0, 0, 0, 0, "R8 wait");
    idle(N * 3, 1, "R8 stopped");
    for (int i = 0; i < 4000; i++) begin
      bit we;
      we = ($urandom % 16) == 0;
      cyc(we, $urandom & 32'h58, $urandom % 2, $urandom % 2,
          ($urandom % 6) == 0, ($urandom % 6) == 0, $urandom % 2, "R2 R3 R6 random");
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule